// File: doc/BRIEF.md
# Pairable Eight-Channel Pulse-Width Modulator

This block produces eight pulse-width modulated outputs from one system clock. Each channel has its own 8-bit period and 8-bit duty value. A channel can count in edge mode, where the counter rises and wraps. It can also count in symmetric mode, where the counter rises and then falls, so the pulse sits in the middle of each period. A per-channel polarity bit decides whether the active part of the period is driven high or low.

Two neighbouring channels can be fused into one 16-bit channel. In a fused pair the even channel holds the upper byte and the odd channel holds the lower byte. The odd channel's controls and pin carry the result, and the even pin is held low.

Each channel counts on one of two clock enables. Each enable divides the system clock by a programmable power of two. Software writes every setting through a plain write port: enable, address and data.

Each channel runs a small state machine with three states:
- `CH_IDLE`: disabled. The output is low and the shadow values follow the live registers.
- `CH_UP`: the counter is rising.
- `CH_DOWN`: the counter is falling. Used in symmetric mode only.

The transitions are:
- enable: `CH_IDLE`→`CH_UP`.
- wrap: `CH_UP`→`CH_UP` at the end of an edge-mode period.
- turn: `CH_UP`→`CH_DOWN` at the top of a symmetric-mode count.
- return: `CH_DOWN`→`CH_UP` at the bottom of the count, which ends a symmetric period.
- disable: any state→`CH_IDLE` when the enable bit clears.

Top module: `pwm_bank`

## Requirements
- R1: After reset all eight outputs are low and every channel is idle.
- R2: In edge mode with period P>0 and duty D, one period lasts P counting ticks. The counter runs 0..P-1 and the channel is active while the counter is below D.
- R3: With the polarity bit set, the active part of the period is driven high. With the polarity bit clear, the output is the inverse: low while active, high otherwise.
- R4: In symmetric mode the counter runs 0..P-1 and then back down P-1..0. A period therefore lasts 2P ticks, and the channel is active for 2·min(D,P) of them.
- R5: A duty of 0 gives a constant inactive output. A duty equal to or greater than the period gives a constant active output.
- R6: Setting pair bit k fuses channels 2k and 2k+1 into one 16-bit channel:
  - period = {period[2k], period[2k+1]} and duty = {duty[2k], duty[2k+1]};
  - the mode, polarity, enable and clock-select bits of channel 2k+1 apply;
  - the result appears on pin 2k+1, and pin 2k stays low.
- R7: Clock enable A ticks once every 2^selA system cycles, and clock enable B once every 2^selB cycles (sel 0..7). A channel uses B when its clock-select bit is 1 and A otherwise.
- R8: New period, duty and mode values written while a channel runs take effect only at the end of the current period.
- R9: Clearing a channel's enable bit forces its output low from the next cycle onward.
- R10: Register map (write-only, 5-bit address, 8-bit data). Writes to any other address change nothing.

  | Address | Contents |
  |---|---|
  | 0x00 | channel enable bits |
  | 0x01 | polarity bits |
  | 0x02 | symmetric-mode bits |
  | 0x03 | pair bits [3:0] |
  | 0x04 | selA in [2:0], selB in [6:4] |
  | 0x05 | clock-select bits |
  | 0x08+n | period of channel n |
  | 0x10+n | duty of channel n |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 8 | PWM output pins, one per channel |

## Verification
The hardest case to reach is the deferred update. The new duty value has to arrive while a period is already under way, and the output must then be seen to keep the old duty until the period boundary. The stimulus finds the start of a period by watching for the output's rising edge with the polarity set. It writes a shorter duty on the next cycle. Eight cycles into the period it checks that the output is still high, which only the old duty allows. Every other timing claim is checked by counting high cycles over a window that is an exact multiple of the expected period, so the result does not depend on the phase of the counter.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_UP   = 2'd1,
        CH_DOWN = 2'd2
    } chan_state_e;

    localparam int unsigned ADDR_EN    = 0;
    localparam int unsigned ADDR_POL   = 1;
    localparam int unsigned ADDR_SYM   = 2;
    localparam int unsigned ADDR_PAIR  = 3;
    localparam int unsigned ADDR_PSC   = 4;
    localparam int unsigned ADDR_CSEL  = 5;
    localparam int unsigned PER_BASE   = 8;
    localparam int unsigned DUTY_BASE  = 16;
    localparam int unsigned PSC_B_LSB  = 4;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    output logic             tick_a,
    output logic             tick_b
);
    localparam int unsigned DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask_a;
    logic [DIV_W-1:0] mask_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + DIV_W'(1);
    end

    always_comb begin
        mask_a = DIV_W'((1 << sel_a) - 1);
        mask_b = DIV_W'((1 << sel_b) - 1);
        tick_a = ((div_cnt & mask_a) == mask_a);
        tick_b = ((div_cnt & mask_b) == mask_b);
    end
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile import pwm_pkg::*; #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned AW    = 5,
    parameter int unsigned SEL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    output logic [NCH-1:0]          ch_en,
    output logic [NCH-1:0]          ch_pol,
    output logic [NCH-1:0]          ch_sym,
    output logic [NCH/2-1:0]        pair_on,
    output logic [SEL_W-1:0]        sel_a,
    output logic [SEL_W-1:0]        sel_b,
    output logic [NCH-1:0]          ch_csel,
    output logic [NCH-1:0][DW-1:0]  per,
    output logic [NCH-1:0][DW-1:0]  duty
);
    localparam int unsigned NPAIR = NCH / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_en   <= '0;
            ch_pol  <= '0;
            ch_sym  <= '0;
            pair_on <= '0;
            sel_a   <= '0;
            sel_b   <= '0;
            ch_csel <= '0;
            per     <= '0;
            duty    <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(ADDR_EN))   ch_en   <= wr_data[NCH-1:0];
            if (wr_addr == AW'(ADDR_POL))  ch_pol  <= wr_data[NCH-1:0];
            if (wr_addr == AW'(ADDR_SYM))  ch_sym  <= wr_data[NCH-1:0];
            if (wr_addr == AW'(ADDR_PAIR)) pair_on <= wr_data[NPAIR-1:0];
            if (wr_addr == AW'(ADDR_PSC)) begin
                sel_a <= wr_data[SEL_W-1:0];
                sel_b <= wr_data[PSC_B_LSB+SEL_W-1:PSC_B_LSB];
            end
            if (wr_addr == AW'(ADDR_CSEL)) ch_csel <= wr_data[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(PER_BASE + i))  per[i]  <= wr_data;
                if (wr_addr == AW'(DUTY_BASE + i)) duty[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel import pwm_pkg::*; #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          pol,
    input  logic          sym,
    input  logic [CW-1:0] per,
    input  logic [CW-1:0] duty,
    output logic          pwm
);
    chan_state_e   st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [CW-1:0] a_per, a_duty;
    logic          a_sym;
    logic          reload;
    logic          active;

    // next-state and counter logic
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        reload = 1'b0;
        unique case (st)
            CH_IDLE: begin
                if (en) begin
                    st_nx  = CH_UP;
                    cnt_nx = '0;
                end
            end
            CH_UP: begin
                if (!en) begin
                    st_nx  = CH_IDLE;
                    cnt_nx = '0;
                end else if (tick) begin
                    if (a_per == '0) begin
                        cnt_nx = '0;
                        reload = 1'b1;
                    end else if (cnt == a_per - CW'(1)) begin
                        if (a_sym) begin
                            st_nx = CH_DOWN;
                        end else begin
                            cnt_nx = '0;
                            reload = 1'b1;
                        end
                    end else begin
                        cnt_nx = cnt + CW'(1);
                    end
                end
            end
            CH_DOWN: begin
                if (!en) begin
                    st_nx  = CH_IDLE;
                    cnt_nx = '0;
                end else if (tick) begin
                    if (cnt == '0) begin
                        st_nx  = CH_UP;
                        reload = 1'b1;
                    end else begin
                        cnt_nx = cnt - CW'(1);
                    end
                end
            end
            default: begin
                st_nx  = CH_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    // state register with shadow copies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= CH_IDLE;
            cnt    <= '0;
            a_per  <= '0;
            a_duty <= '0;
            a_sym  <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            if (st == CH_IDLE || reload) begin
                a_per  <= per;
                a_duty <= duty;
                a_sym  <= sym;
            end
        end
    end

    // output logic
    always_comb begin
        active = (cnt < a_duty);
        if (st == CH_IDLE) pwm = 1'b0;
        else               pwm = pol ? active : !active;
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != CH_IDLE && a_per != '0) |-> (cnt < a_per));

    assert_down_only_sym_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_DOWN) |-> a_sym);

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != CH_IDLE && en && !reload) |=> ($stable(a_duty) && $stable(a_per)));

    assert_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank import pwm_pkg::*; #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned AW    = 5,
    parameter int unsigned SEL_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic [NCH-1:0] pwm_out
);
    localparam int unsigned NPAIR = NCH / 2;
    localparam int unsigned CW    = 2 * DW;

    logic [NCH-1:0]         ch_en, ch_pol, ch_sym, ch_csel;
    logic [NPAIR-1:0]       pair_on;
    logic [SEL_W-1:0]       sel_a, sel_b;
    logic [NCH-1:0][DW-1:0] per, duty;
    logic                   tick_a, tick_b;

    pwm_regfile #(.NCH(NCH), .DW(DW), .AW(AW), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ch_en   (ch_en),
        .ch_pol  (ch_pol),
        .ch_sym  (ch_sym),
        .pair_on (pair_on),
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .ch_csel (ch_csel),
        .per     (per),
        .duty    (duty)
    );

    pwm_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .tick_a (tick_a),
        .tick_b (tick_b)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CW-1:0] per_i, duty_i;
        logic          en_i, tick_i, pwm_i;

        if (i % 2 == 1) begin : g_odd
            assign per_i  = pair_on[i/2] ? {per[i-1], per[i]}   : {{DW{1'b0}}, per[i]};
            assign duty_i = pair_on[i/2] ? {duty[i-1], duty[i]} : {{DW{1'b0}}, duty[i]};
            assign en_i   = ch_en[i];
        end else begin : g_even
            assign per_i  = {{DW{1'b0}}, per[i]};
            assign duty_i = {{DW{1'b0}}, duty[i]};
            assign en_i   = ch_en[i] & ~pair_on[i/2];
        end

        assign tick_i = ch_csel[i] ? tick_b : tick_a;

        pwm_channel #(.CW(CW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_i),
            .tick  (tick_i),
            .pol   (ch_pol[i]),
            .sym   (ch_sym[i]),
            .per   (per_i),
            .duty  (duty_i),
            .pwm   (pwm_i)
        );

        assign pwm_out[i] = pwm_i;
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair_chk
        assert_even_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pair_on[p] |=> !pwm_out[2*p]);
    end
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pwm_out;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    pwm_bank u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = 5'(addr);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int ch, input int n, output int highs);
        highs = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) highs++;
        end
    endtask

    task automatic t_reset;
        check("R1 outputs after reset", int'(pwm_out), 0);
    endtask

    task automatic t_left_and_pol;
        int h;
        wr(8, 10); wr(16, 3); wr(1, 8'h01); wr(0, 8'h01);
        settle(30);
        measure(0, 100, h);
        check("R2 edge mode per10 duty3", h, 30);
        wr(1, 8'h00);
        settle(5);
        measure(0, 100, h);
        check("R3 inverted polarity", h, 70);
        wr(1, 8'h01);
    endtask

    task automatic t_symmetric;
        int h;
        wr(10, 6); wr(18, 2); wr(2, 8'h04); wr(1, 8'h05); wr(0, 8'h05);
        settle(30);
        measure(2, 120, h);
        check("R4 symmetric per6 duty2", h, 40);
        wr(18, 3);
        settle(30);
        measure(2, 120, h);
        check("R4 symmetric per6 duty3", h, 60);
        wr(18, 6);
        settle(30);
        measure(2, 120, h);
        check("R5 symmetric duty equal period", h, 120);
    endtask

    task automatic t_extremes;
        int h;
        wr(16, 0);
        settle(30);
        measure(0, 100, h);
        check("R5 duty zero", h, 0);
        wr(16, 12);
        settle(30);
        measure(0, 100, h);
        check("R5 duty above period", h, 100);
        wr(16, 3);
        settle(30);
    endtask

    task automatic t_prescale;
        int h;
        wr(4, 8'h02);
        settle(100);
        measure(0, 400, h);
        check("R7 clock A divide by 4", h, 120);
        wr(4, 8'h12); wr(5, 8'h01);
        settle(100);
        measure(0, 200, h);
        check("R7 clock B divide by 2", h, 60);
        wr(4, 8'h00); wr(5, 8'h00);
        settle(60);
    endtask

    task automatic t_pair;
        int h;
        wr(14, 8'h01); wr(15, 8'h02); wr(22, 8'h00); wr(23, 8'h81);
        wr(3, 8'h08); wr(1, 8'hC5); wr(0, 8'hC5);
        settle(10);
        measure(7, 516, h);
        check("R6 fused pair 258/129 on odd pin", h, 258);
        measure(6, 516, h);
        check("R6 even pin of fused pair", h, 0);
    endtask

    task automatic t_deferred;
        int h;
        logic prev;
        wr(9, 20); wr(17, 15); wr(1, 8'hC7); wr(0, 8'hC7);
        settle(50);
        prev = pwm_out[1];
        @(negedge clk);
        while (!(pwm_out[1] && !prev)) begin
            prev = pwm_out[1];
            @(negedge clk);
        end
        wr(17, 5);
        settle(7);
        check("R8 old duty holds mid-period", int'(pwm_out[1]), 1);
        settle(40);
        measure(1, 200, h);
        check("R8 new duty after boundary", h, 50);
    endtask

    task automatic t_disable;
        int h;
        wr(0, 8'hC5);
        settle(1);
        check("R9 output low after disable", int'(pwm_out[1]), 0);
        measure(1, 60, h);
        check("R9 stays low while disabled", h, 0);
    endtask

    task automatic t_unused_addr;
        int h;
        wr(31, 8'hFF); wr(6, 8'hFF); wr(24, 8'hFF);
        settle(20);
        measure(0, 100, h);
        check("R10 unused address leaves ch0 intact", h, 30);
        measure(3, 50, h);
        check("R10 unused address enables nothing", h, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        settle(3);
        t_reset();
        rst_n = 1'b1;
        settle(2);
        t_reset();
        t_left_and_pol();
        t_symmetric();
        t_extremes();
        t_prescale();
        t_pair();
        t_deferred();
        t_disable();
        t_unused_addr();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule